// File: doc/BRIEF.md
# Addressed SPI Read Slave with Check Byte

This block is the serial front end of a diagnostic slave. A master selects it with an active-low select line and clocks out one 16-bit frame. The slave shifts in the first eight bits as an instruction byte, MSB first. That byte carries a two-bit chip address and a five-bit instruction code. While the instruction arrives, the slave returns a check byte. The check byte has a fixed marker pattern and a flag that tells whether the previous transfer was accepted. In the second byte the slave returns one of three things: a constant identifier, a constant version byte, or a snapshot of an external diagnostic byte. The slave also raises a one-cycle clear strobe for the diagnostic source after a good diagnostic read.

The serial pins are oversampled by the system clock through synchronisers and edge detectors. The serial clock idles low. The slave samples the data input on each falling edge and updates its output on each rising edge. The output enable stays low while the slave is deselected and during the two address bit times. If the address does not match, it stays low for the whole frame. The decision about a frame is made when the select line rises, so it is taken only after every bit has been counted.

Top module: `spi_diag_slave`

## Requirements
- R1: The data input is sampled on falling serial-clock edges and the output changes on rising edges, both MSB first. Bits 8 to 15 received in a frame do not affect the returned data.
- R2: `so_oe` is 0 while `ss_n` is high and during output bit times 0 and 1. With a matching address it is 1 for output bit times 2 to 15.
- R3: When instruction bits 7:6 differ from the chip address 00, `so_oe` stays 0 for the whole frame, no clear strobe is issued, and the error flag keeps its value.
- R4: Output byte 0 carries the pattern 1,0,1,0,1 in bits 5:1. Its bit 0 is the error flag, which is 1 when the previous address-matched frame was rejected.
- R5: Instruction code (bits 5:1) 00000 returns A1h in output byte 1.
- R6: Instruction code 00001 returns the version byte. Its upper nibble is the software-release field and its lower nibble is the mask-set field, both 0, so the byte is 00h.
- R7: Instruction code 00100 returns `diag_data` as sampled at the start of output byte 1.
- R8: Any other instruction code returns FFh and marks the frame as rejected.
- R9: A frame with a count of falling edges other than 16 is rejected and issues no clear strobe.
- R10: `diag_clr` pulses high for exactly one system-clock cycle after the select line rises on an accepted code-00100 frame, and at no other time.
- R11: After reset, `so_oe` and `diag_clr` are 0 and the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset of the interface |
| ss_n | input | 1 | Active-low slave select |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| diag_data | input | 8 | Diagnostic byte returned by code 00100 |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so`. When it is 0 the pin is high impedance |
| diag_clr | output | 1 | One-cycle clear strobe for the diagnostic source |

## Verification
All 32 instruction codes are swept, and bit 0 of the instruction alternates across the sweep. The diagnostic byte changes on every frame. This sweep separates the three used codes from the unused ones and shows that each frame's error flag carries the previous frame's result. Frames with the three non-zero addresses show that the output stays undriven and that the error flag is held. Frames of 15 and 17 clocks show that the edge count alone rejects an access and blocks the clear strobe. Identifier reads with different trailing data bits show that bits received after the instruction are ignored.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;
  localparam int FRAME_BITS = 16;
  localparam int BYTE_BITS  = 8;
  localparam int CODE_W     = 5;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  localparam logic [CODE_W-1:0] OP_IDENT = 5'b00000;
  localparam logic [CODE_W-1:0] OP_VERS  = 5'b00001;
  localparam logic [CODE_W-1:0] OP_DIAG  = 5'b00100;

  localparam logic [4:0] MARKER = 5'b10101;

  function automatic logic op_known(input logic [CODE_W-1:0] op);
    return (op == OP_IDENT) || (op == OP_VERS) || (op == OP_DIAG);
  endfunction
endpackage

// File: rtl/spi_diag_sync.sv
module spi_diag_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{rst_val[b]}};
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_diag_rx.sv
module spi_diag_rx
  import spi_diag_pkg::*;
#(
  parameter logic [1:0] CHIP_ADDR = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_low,
  input  logic              ss_fall,
  input  logic              ss_rise,
  input  logic              sck_fall,
  input  logic              si_s,
  output logic [CODE_W-1:0] op,
  output logic              addr_ok,
  output logic              err_q,
  output logic              clr_q
);
  logic [CNT_W-1:0] fcnt;
  logic [5:0]       sh;

  assign op = sh[5:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt    <= '0;
      sh      <= '0;
      addr_ok <= 1'b0;
      err_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (ss_fall) begin
        fcnt    <= '0;
        addr_ok <= 1'b0;
      end else if (ss_low && sck_fall) begin
        if (fcnt != CNT_MAX) fcnt <= fcnt + 1'b1;
        if (fcnt < CNT_W'(BYTE_BITS)) sh <= {sh[4:0], si_s};
        if (fcnt == CNT_W'(1)) addr_ok <= ({sh[0], si_s} == CHIP_ADDR);
      end
      if (ss_rise && addr_ok) begin
        err_q <= !((fcnt == CNT_FULL) && op_known(op));
        clr_q <= (fcnt == CNT_FULL) && (op == OP_DIAG);
      end
    end
  end

  a_r10_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);
  a_r9_clr_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> $past(fcnt) == CNT_FULL);
  a_r3_clr_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> $past(addr_ok));
  a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CNT_MAX);
endmodule

// File: rtl/spi_diag_tx.sv
module spi_diag_tx
  import spi_diag_pkg::*;
#(
  parameter logic [7:0] ID_VALUE      = 8'hA1,
  parameter logic [3:0] SW_RELEASE    = 4'h0,
  parameter logic [3:0] MASK_REVISION = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_low,
  input  logic              sck_rise,
  input  logic              addr_ok,
  input  logic              err_q,
  input  logic [CODE_W-1:0] op,
  input  logic [7:0]        diag_data,
  output logic              so_q,
  output logic              oe_q
);
  logic [CNT_W-1:0] rcnt;
  logic [7:0]       hold;
  logic [7:0]       nxt_byte;
  logic [7:0]       chk_byte;
  logic [2:0]       sel;

  assign chk_byte = {2'b00, MARKER, err_q};
  assign sel      = 3'd7 - rcnt[2:0];

  always_comb begin
    case (op)
      OP_IDENT: nxt_byte = ID_VALUE;
      OP_VERS:  nxt_byte = {SW_RELEASE, MASK_REVISION};
      OP_DIAG:  nxt_byte = diag_data;
      default:  nxt_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0;
      hold <= '0;
      so_q <= 1'b0;
      oe_q <= 1'b0;
    end else if (!ss_low) begin
      rcnt <= '0;
      oe_q <= 1'b0;
    end else if (sck_rise) begin
      if (rcnt != CNT_MAX) rcnt <= rcnt + 1'b1;
      oe_q <= addr_ok && (rcnt >= CNT_W'(2));
      if (rcnt < CNT_W'(BYTE_BITS)) begin
        so_q <= chk_byte[sel];
      end else if (rcnt == CNT_W'(BYTE_BITS)) begin
        hold <= nxt_byte;
        so_q <= nxt_byte[7];
      end else if (rcnt < CNT_FULL) begin
        so_q <= hold[sel];
      end else begin
        so_q <= 1'b0;
      end
    end
  end

  a_r2_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_low |=> !oe_q);
  a_r2_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> rcnt >= CNT_W'(3));
  a_r3_drive_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> addr_ok);
endmodule

// File: rtl/spi_diag_slave.sv
module spi_diag_slave
  import spi_diag_pkg::*;
#(
  parameter int         SYNC_STAGES   = 2,
  parameter logic [1:0] CHIP_ADDR     = 2'b00,
  parameter logic [7:0] ID_VALUE      = 8'hA1,
  parameter logic [3:0] SW_RELEASE    = 4'h0,
  parameter logic [3:0] MASK_REVISION = 4'h0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ss_n,
  input  logic       sck,
  input  logic       si,
  input  logic [7:0] diag_data,
  output logic       so,
  output logic       so_oe,
  output logic       diag_clr
);
  logic [2:0] pins_s;
  logic       ss_n_d, sck_d;
  logic       ss_low, ss_fall, ss_rise, sck_rise, sck_fall;
  logic [CODE_W-1:0] op;
  logic       addr_ok, err_q, clr_q, so_q, oe_q;

  spi_diag_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ss_n, sck, si}),
    .rst_val(3'b100), .dout(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_n_d <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      ss_n_d <= pins_s[2];
      sck_d  <= pins_s[1];
    end
  end

  assign ss_low   = !pins_s[2];
  assign ss_fall  = ss_n_d && !pins_s[2];
  assign ss_rise  = !ss_n_d && pins_s[2];
  assign sck_rise = !sck_d && pins_s[1];
  assign sck_fall = sck_d && !pins_s[1];

  spi_diag_rx #(.CHIP_ADDR(CHIP_ADDR)) u_rx (
    .clk(clk), .rst_n(rst_n), .ss_low(ss_low), .ss_fall(ss_fall),
    .ss_rise(ss_rise), .sck_fall(sck_fall), .si_s(pins_s[0]),
    .op(op), .addr_ok(addr_ok), .err_q(err_q), .clr_q(clr_q)
  );

  spi_diag_tx #(.ID_VALUE(ID_VALUE), .SW_RELEASE(SW_RELEASE),
                .MASK_REVISION(MASK_REVISION)) u_tx (
    .clk(clk), .rst_n(rst_n), .ss_low(ss_low), .sck_rise(sck_rise),
    .addr_ok(addr_ok), .err_q(err_q), .op(op), .diag_data(diag_data),
    .so_q(so_q), .oe_q(oe_q)
  );

  assign so       = so_q;
  assign so_oe    = oe_q;
  assign diag_clr = clr_q;
endmodule

// File: tb/spi_diag_slave_tb.sv
module spi_diag_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic [7:0] diag_data = 8'h00;
  logic so, so_oe, diag_clr;
  int checks = 0, failures = 0, clr_cnt = 0;
  logic prev_err = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_diag_slave u_dut (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .si(si),
    .diag_data(diag_data), .so(so), .so_oe(so_oe), .diag_clr(diag_clr)
  );

  always @(posedge clk) if (diag_clr) clr_cnt <= clr_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] instr, input int nclk, input logic [7:0] tail,
                       output logic [15:0] word, output logic oe_early, output int oe_cnt);
    word = '0; oe_early = 1'b0; oe_cnt = 0;
    ss_n = 1'b0; waitn(8);
    for (int k = 0; k < nclk; k++) begin
      sck = 1'b1;
      si = (k < 8) ? instr[7-k] : ((k < 16) ? tail[15-k] : 1'b0);
      waitn(6);
      if (k < 16) word[15-k] = so;
      if (k < 2) oe_early = oe_early | so_oe;
      else if (k < 16) oe_cnt += int'(so_oe);
      waitn(2);
      sck = 1'b0; waitn(8);
    end
    waitn(8); ss_n = 1'b1; waitn(20);
  endtask

  function automatic logic [7:0] expect_byte(input logic [4:0] op, input logic [7:0] d);
    case (op)
      5'b00000: return 8'hA1;
      5'b00001: return 8'h00;
      5'b00100: return d;
      default:  return 8'hFF;
    endcase
  endfunction

  // Full matching frame with checks of every output field
  task automatic good_frame(input logic [4:0] op, input logic b0, input logic [7:0] tail);
    logic [15:0] w; logic early; int cnt; int c0; logic known;
    c0 = clr_cnt;
    frame({2'b00, op, b0}, 16, tail, w, early, cnt);
    chk("R2 oe in address bits", 32'(early), 0);
    chk("R2 oe bit times 2..15", cnt, 14);
    chk("R4 marker", 32'(w[13:9]), 32'h15);
    chk("R4 previous error flag", 32'(w[8]), 32'(prev_err));
    case (op)
      5'b00000: chk("R5 identifier", 32'(w[7:0]), 32'(expect_byte(op, diag_data)));
      5'b00001: chk("R6 version", 32'(w[7:0]), 32'(expect_byte(op, diag_data)));
      5'b00100: chk("R7 diagnostic", 32'(w[7:0]), 32'(expect_byte(op, diag_data)));
      default:  chk("R8 unused code", 32'(w[7:0]), 32'hFF);
    endcase
    known = (op == 5'b00000) || (op == 5'b00001) || (op == 5'b00100);
    chk("R10 clear strobes", clr_cnt - c0, (op == 5'b00100) ? 1 : 0);
    prev_err = !known;
  endtask

  initial begin
    logic [15:0] w; logic early; int cnt; int c0;
    waitn(5);
    chk("R11 so_oe at reset", 32'(so_oe), 0);
    chk("R11 diag_clr at reset", 32'(diag_clr), 0);
    rst_n = 1'b1; waitn(5);
    chk("R2 oe while deselected", 32'(so_oe), 0);

    // R1 R4 R5 R6 R7 R8 sweep of every code
    for (int op = 0; op < 32; op++) begin
      diag_data = 8'(op * 37 + 11);
      good_frame(5'(op), op[0], 8'(op * 5));
    end

    // R1 trailing data bits are ignored
    good_frame(5'b00000, 1'b0, 8'h00);
    good_frame(5'b00000, 1'b1, 8'hFF);
    good_frame(5'b11111, 1'b0, 8'h00);  // sets error flag

    // R3 address mismatch
    for (int a = 1; a < 4; a++) begin
      c0 = clr_cnt;
      frame({2'(a), 5'b00100, 1'b0}, 16, 8'h00, w, early, cnt);
      chk("R3 no drive early", 32'(early), 0);
      chk("R3 no drive frame", cnt, 0);
      chk("R3 no clear strobe", clr_cnt - c0, 0);
    end
    good_frame(5'b00000, 1'b0, 8'h3C);  // flag still 1 from before mismatches

    // R9 wrong clock counts
    diag_data = 8'h5A;
    c0 = clr_cnt;
    frame({2'b00, 5'b00100, 1'b0}, 15, 8'h00, w, early, cnt);
    chk("R9 short frame no strobe", clr_cnt - c0, 0);
    chk("R4 flag during short frame", 32'(w[8]), 0);
    prev_err = 1'b1;
    good_frame(5'b00001, 1'b0, 8'h00);
    c0 = clr_cnt;
    frame({2'b00, 5'b00100, 1'b0}, 17, 8'h00, w, early, cnt);
    chk("R9 long frame no strobe", clr_cnt - c0, 0);
    chk("R7 data during long frame", 32'(w[7:0]), 32'h5A);
    prev_err = 1'b1;
    good_frame(5'b00100, 1'b0, 8'h00);
    good_frame(5'b00000, 1'b0, 8'h00);
    chk("R2 oe after frames", 32'(so_oe), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule